// File: doc/BRIEF.md
# Radix-4 Iterative Modular Multiplier

This block computes R = (A*B) mod P for unsigned N-bit operands with A < P and B < P. It takes no precomputed reduction constant. The host gives the modulus and three times the modulus. Each clock the block consumes one pair of multiplier bits, starting with the least significant pair, so one operation takes N/2 clock steps.

A single-cycle start pulse captures the modulus, the tripled modulus and the multiplier into registers. The multiplicand A becomes the first partial remainder. In each later step the running partial remainder is multiplied by four and reduced against P, 2P and 3P. It is then multiplied by the current bit pair and reduced against P and 2P. The product is added into the accumulated remainder, which is reduced against P. Every stored value therefore stays below P. When the last pair is consumed, the result is latched and a one-cycle done pulse is issued.

Top module: `mm_radix4_top`

## Requirements
- R1: When start is accepted with op_a < modulus and op_b < modulus, the value of result after the matching done pulse equals (op_a*op_b) mod modulus (for example 37*39 mod 77 = 57), provided modulus_x3 equals 3*modulus.
- R2: done is high for exactly one cycle. It rises on the N/2-th rising edge, counting the edge that accepts start as the first. With N = 8 that is 4 edges, and with N = 10 it is 5.
- R3: result changes only on the edge that raises done. At all other times it holds its value, including while idle and during the next operation.
- R4: While busy is high, start is ignored. The operation in flight completes with its own operands and its own timing.
- R5: The operands and moduli are sampled only on the accepting edge. Changes on op_a, op_b, modulus or modulus_x3 during an operation do not affect its result.
- R6: A zero multiplicand or a zero multiplier gives a result of 0.
- R7: Operands at the top of the range do not overflow. For example, with modulus = 2^N-1 and op_a = op_b = modulus-1, the result is 1.
- R8: start may be asserted in the cycle right after done. That operation is accepted at once and completes with the same latency.
- R9: While rst is high, and on the first cycle after it, busy, done and result are 0. busy is high from the accepting edge until the edge that raises done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; accepted only while idle |
| op_a | input | N | Multiplicand, below modulus |
| op_b | input | N | Multiplier, below modulus |
| modulus | input | N | Modulus P |
| modulus_x3 | input | N+2 | Tripled modulus 3P |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | N | Latched (A*B) mod P |

## Verification
The bench targets the following cases:
- **Extreme operands.** A modulus of 2^N-1 with both operands at modulus-1 exposes a datapath too narrow to hold 4r or 3P; the result would then wrap to a wrong value.
- **Zero operands.** A zero multiplier and a zero multiplicand show a stale accumulator or a wrongly seeded first remainder.
- **High-bit multipliers.** Multipliers with only high bits set show reversed pair order or a pair index off by one, since the product would then miss a factor of four.
- **Start during an operation.** A start pulse in the middle of an operation, and operand changes after acceptance, catch a block that restarts or reads live inputs; it would report the second product or a mixture.
- **Back-to-back starts.** A start in the cycle after done catches a controller that loses the request.

// File: rtl/mm_radix4_pkg.sv
package mm_radix4_pkg;

    typedef enum logic {
        MM_IDLE = 1'b0,
        MM_RUN  = 1'b1
    } mm_state_e;

    // number of clock steps for an n-bit multiplier
    function automatic int mm_steps(input int n);
        return n / 2;
    endfunction

    // width of a down-counter able to hold steps-1
    function automatic int mm_cnt_w(input int steps);
        return (steps < 2) ? 1 : $clog2(steps) + 1;
    endfunction

endpackage

// File: rtl/mm_reduce.sv
// Subtracts the largest multiple k*P (k = 1..K) that does not drive x
// negative. The caller guarantees x < (K+1)*P.
module mm_reduce #(
    parameter int W = 10,
    parameter int K = 3
) (
    input  logic [W-1:0]        x,
    input  logic [K-1:0][W-1:0] mults,
    output logic [W-1:0]        y
);
    logic [K-1:0][W:0] diff;
    logic [K-1:0]      fits;

    for (genvar k = 0; k < K; k++) begin : g_sub
        assign diff[k] = {1'b0, x} - {1'b0, mults[k]};
        assign fits[k] = ~diff[k][W];
    end

    always_comb begin
        y = x;
        for (int k = 0; k < K; k++) begin
            if (fits[k]) y = diff[k][W-1:0];
        end
    end
endmodule

// File: rtl/mm_former.sv
// Partial remainder step: r_out = (4 * r_in) mod P, for r_in < P.
module mm_former #(
    parameter int W = 10
) (
    input  logic [W-1:0] r_in,
    input  logic [W-1:0] p1,
    input  logic [W-1:0] p2,
    input  logic [W-1:0] p3,
    output logic [W-1:0] r_out
);
    logic [W-1:0]        quad;
    logic [2:0][W-1:0]   mults;

    assign quad  = {r_in[W-3:0], 2'b00};
    assign mults = {p3, p2, p1};

    mm_reduce #(.W(W), .K(3)) u_red (
        .x     (quad),
        .mults (mults),
        .y     (r_out)
    );
endmodule

// File: rtl/mm_pairmul.sv
// Two-bit modular product: (r * (2*pair[1] + pair[0])) mod P, for r < P.
module mm_pairmul #(
    parameter int W = 10
) (
    input  logic [W-1:0] r,
    input  logic [1:0]   pair,
    input  logic [W-1:0] p1,
    input  logic [W-1:0] p2,
    output logic [W-1:0] prod
);
    logic [W-1:0]      twice;
    logic [W-1:0]      once;
    logic [W-1:0]      sum;
    logic [1:0][W-1:0] mults;

    assign twice = pair[1] ? {r[W-2:0], 1'b0} : '0;
    assign once  = pair[0] ? r : '0;
    assign sum   = twice + once;
    assign mults = {p2, p1};

    mm_reduce #(.W(W), .K(2)) u_red (
        .x     (sum),
        .mults (mults),
        .y     (prod)
    );
endmodule

// File: rtl/mm_accum.sv
// Remainder adder: (a + b) mod P, for a, b < P.
module mm_accum #(
    parameter int W = 10
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] p1,
    output logic [W-1:0] s
);
    logic [W-1:0]      sum;
    logic [0:0][W-1:0] mults;

    assign sum   = a + b;
    assign mults = p1;

    mm_reduce #(.W(W), .K(1)) u_red (
        .x     (sum),
        .mults (mults),
        .y     (s)
    );
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
    import mm_radix4_pkg::*;
#(
    parameter int STEPS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step_en,
    output logic last,
    output logic busy,
    output logic done
);
    localparam int CW = mm_cnt_w(STEPS);

    mm_state_e     state_q;
    logic [CW-1:0] cnt_q;

    assign load    = (state_q == MM_IDLE) && start;
    assign step_en = (state_q == MM_RUN);
    assign last    = step_en && (cnt_q == CW'(1));
    assign busy    = step_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MM_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= last;
            if (load) begin
                state_q <= MM_RUN;
                cnt_q   <= CW'(STEPS - 1);
            end else if (step_en) begin
                cnt_q <= cnt_q - CW'(1);
                if (last) state_q <= MM_IDLE;
            end
        end
    end

    // R2: the completion pulse lasts a single cycle
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: a start during a run neither restarts nor stalls the countdown
    p_busy_ignore_r4: assert property (@(posedge clk) disable iff (rst)
        (step_en && !last) |=> (step_en && cnt_q == $past(cnt_q) - CW'(1)));

    // R9: idle follows the final step
    p_idle_after_last_r9: assert property (@(posedge clk) disable iff (rst)
        last |=> (state_q == MM_IDLE && done));
endmodule

// File: rtl/mm_radix4_top.sv
module mm_radix4_top
    import mm_radix4_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    input  logic [N-1:0]   modulus,
    input  logic [N+1:0]   modulus_x3,
    output logic           busy,
    output logic           done,
    output logic [N-1:0]   result
);
    localparam int W     = N + 2;
    localparam int STEPS = mm_steps(N);

    logic         load, step_en, last;
    logic [W-1:0] p_q, p3_q, r_q, acc_q;
    logic [N-1:0] b_q, res_q;

    logic [W-1:0] sel_p1, sel_p2, r_next, pm_in, pm_out, acc_next;
    logic [1:0]   pair;

    mm_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .load    (load),
        .step_en (step_en),
        .last    (last),
        .busy    (busy),
        .done    (done)
    );

    // On the accepting edge the product uses the live modulus and A as r0.
    assign sel_p1 = load ? {2'b00, modulus} : p_q;
    assign sel_p2 = {sel_p1[W-2:0], 1'b0};
    assign pm_in  = load ? {2'b00, op_a} : r_next;
    assign pair   = load ? op_b[1:0] : b_q[1:0];

    mm_former #(.W(W)) u_former (
        .r_in  (r_q),
        .p1    (p_q),
        .p2    ({p_q[W-2:0], 1'b0}),
        .p3    (p3_q),
        .r_out (r_next)
    );

    mm_pairmul #(.W(W)) u_pairmul (
        .r    (pm_in),
        .pair (pair),
        .p1   (sel_p1),
        .p2   (sel_p2),
        .prod (pm_out)
    );

    mm_accum #(.W(W)) u_accum (
        .a  (acc_q),
        .b  (pm_out),
        .p1 (p_q),
        .s  (acc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q   <= '0;
            p3_q  <= '0;
            b_q   <= '0;
            r_q   <= '0;
            acc_q <= '0;
            res_q <= '0;
        end else if (load) begin
            p_q   <= {2'b00, modulus};
            p3_q  <= modulus_x3;
            b_q   <= op_b >> 2;
            r_q   <= {2'b00, op_a};
            acc_q <= pm_out;
        end else if (step_en) begin
            b_q   <= b_q >> 2;
            r_q   <= r_next;
            acc_q <= acc_next;
            if (last) res_q <= acc_next[N-1:0];
        end
    end

    assign result = res_q;

    // R3: the visible result only moves on the completing step
    p_result_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(res_q));

    // R5: captured modulus matches the port value on the accepting edge
    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> (p_q == {2'b00, $past(modulus)}));

    // R7: running remainders never reach the modulus
    p_rem_below_r7: assert property (@(posedge clk) disable iff (rst)
        step_en |-> (r_q < p_q && acc_q < p_q));

    // R1: the completed value is a proper residue
    p_result_range_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> ({2'b00, res_q} < p_q));
endmodule

// File: tb/mm_radix4_tb_top.sv
module mm_radix4_tb_top;
    localparam int N     = 8;
    localparam int STEPS = N / 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [N-1:0] op_a = '0, op_b = '0, modulus = '0;
    logic [N+1:0] modulus_x3 = '0;
    logic         busy, done;
    logic [N-1:0] result;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R9";

    always #5 clk = ~clk;

    mm_radix4_top #(.N(N)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .op_a       (op_a),
        .op_b       (op_b),
        .modulus    (modulus),
        .modulus_x3 (modulus_x3),
        .busy       (busy),
        .done       (done),
        .result     (result)
    );

    // behavioural interface model
    bit      m_busy = 0, m_done = 0;
    int      m_cnt = 0;
    longint  m_pend = 0, m_res = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            m_busy = 0; m_done = 0; m_cnt = 0; m_res = 0;
        end else begin
            m_done = 0;
            if (!m_busy && start) begin
                m_busy = 1;
                m_cnt  = STEPS - 1;
                m_pend = (longint'(op_a) * longint'(op_b)) % longint'(modulus);
            end else if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1; m_res = m_pend;
                end
            end
        end
    end

    task automatic check(input string req, input longint act, input longint exp,
                         input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && cycles > 0) begin
            check(cur_req, busy,   m_busy, "busy vs model");
            check(cur_req, done,   m_done, "done vs model");
            check(cur_req, result, m_res,  "result vs model");
        end
    end

    task automatic drive(input longint a, input longint b, input longint p);
        op_a = N'(a); op_b = N'(b); modulus = N'(p); modulus_x3 = (N+2)'(3 * p);
    endtask

    // start at a negedge, return at the negedge where done is seen
    task automatic run_op(input longint a, input longint b, input longint p,
                          input string req);
        int lat;
        @(negedge clk);
        cur_req = req;
        drive(a, b, p);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check("R2", lat, STEPS, "latency");
        check(req, result, (a * b) % p, "result");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9", busy,   0, "reset busy");
        check("R9", done,   0, "reset done");
        check("R9", result, 0, "reset result");
        rst = 1'b0;
        @(negedge clk);
        check("R9", result, 0, "post-reset result");

        run_op(37, 39, 77, "R1");
        check("R1", result, 57, "known product");
        run_op(0, 200, 251, "R6");
        run_op(199, 0, 251, "R6");
        run_op(254, 254, 255, "R7");
        check("R7", result, 1, "max operands");
        run_op(253, 252, 255, "R7");
        run_op(100, 8'h80, 251, "R1");
        run_op(77, 8'hC0, 211, "R1");
        run_op(5, 1, 7, "R1");

        // R3: result holds while idle
        cur_req = "R3";
        repeat (5) @(negedge clk);
        check("R3", result, (longint'(5) * 1) % 7, "held idle");

        // R4: start during busy ignored
        @(negedge clk);
        cur_req = "R4";
        drive(120, 33, 241); start = 1'b1;
        @(negedge clk);
        drive(7, 9, 11);
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check("R4", result, (120 * 33) % 241, "second start ignored");
        @(negedge clk);
        check("R4", busy, 0, "no restart after ignored start");

        // R5: operand changes after acceptance ignored
        @(negedge clk);
        cur_req = "R5";
        drive(90, 61, 97); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drive(3, 3, 5);
        while (!done) @(negedge clk);
        check("R5", result, (90 * 61) % 97, "captured operands");

        // R8: back-to-back start right after done
        @(negedge clk);
        cur_req = "R8";
        drive(44, 55, 101); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check("R8", result, (44 * 55) % 101, "first of pair");
        drive(66, 17, 131); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k < STEPS; k++) begin
            check("R3", result, (44 * 55) % 101, "held during next op");
            @(negedge clk);
        end
        check("R8", done, 1, "second done on time");
        check("R8", result, (66 * 17) % 131, "second of pair");

        // R1: sweep of pseudo-random operands
        begin
            int unsigned seed = 32'h1234_5678;
            for (int i = 0; i < 150; i++) begin
                longint p, a, b;
                seed = seed * 1103515245 + 12345;
                p = 2 + (seed >> 8) % 254;
                seed = seed * 1103515245 + 12345;
                a = (seed >> 8) % p;
                seed = seed * 1103515245 + 12345;
                b = (seed >> 8) % p;
                run_op(a, b, p, "R1");
            end
        end

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule